// File: doc/BRIEF.md
# Block Cipher Chaining Unit

This unit sits between a stream of 128-bit data blocks and an external single-block cipher core. It adds the chaining layer on top of that core: plain codebook operation, cipher-block chaining, or counter operation. For each accepted block it builds the word that goes to the cipher, issues one request, waits for the response, forms the output block and updates the chaining state it keeps from block to block.

The chaining state is a 128-bit register. Software loads it through an initialization-vector write port. A copy of the last written vector is kept, so that a change of chaining mode can restart the chain without a new write. In counter operation the upper 96 bits serve as a fixed nonce, and only the low 32-bit field advances. The cipher core is reached through a request pulse carrying the input word and a direction bit, and it answers with an acknowledge pulse carrying the result after any latency. The unit handles one block at a time.

Top module: `block_chain_unit`

## Requirements
- R1: After reset, `inReady` is high and `outValid` and `cipReq` are low. The stored initialization vector and the chaining value are zero, so a chaining block sent before any vector write chains against zero.
- R2: Mode encoding on `mode`: 0 = codebook (ECB), 1 = block chaining (CBC), 2 = counter (CTR), 3 = treated as codebook. Codebook is the reset mode. In codebook mode the cipher input is the data block and the output is the cipher result. The chaining value is never used, so equal inputs give equal outputs.
- R3: In codebook and CBC modes, `cipDecrypt` follows the `decrypt` input sampled when the block was accepted.
- R4: CBC encryption sends the data XOR the chaining value to the cipher, outputs the cipher result, and makes that result the new chaining value.
- R5: The first CBC block after a vector write chains against the written vector.
- R6: CBC decryption sends the data block unchanged to the cipher, outputs the cipher result XOR the chaining value, and makes the incoming ciphertext the new chaining value.
- R7: CTR mode sends the chaining value (nonce in bits 127:32, counter in bits 31:0) to the cipher and outputs the cipher result XOR the data. After each block the counter field advances by one modulo 2^32, and bits 127:32 do not change.
- R8: In CTR mode the cipher is always driven in the encrypt direction (`cipDecrypt` low), for encryption and for decryption alike.
- R9: A vector write, or a change of `mode` seen while idle, restarts the chain before the next block. A write loads the written value. A mode change reloads the last written vector.
- R10: A vector write pulse while a block is in progress is ignored. It changes neither the stored vector nor the chaining value.
- R11: `cipReq` is a one-cycle pulse in the cycle after a block is accepted (`inValid` and `inReady` high at a clock edge). `outValid` is a one-cycle pulse in the cycle after `cipAck` is seen. `inReady` is low while a block is in progress or while `ivWrite` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Chaining mode select (0 ECB, 1 CBC, 2 CTR, 3 as ECB) |
| decrypt | input | 1 | Direction: 1 decrypt, 0 encrypt |
| ivWrite | input | 1 | Write strobe for the initialization vector |
| ivIn | input | 128 | Initialization vector / counter block value |
| inValid | input | 1 | Input block present |
| inReady | output | 1 | Unit can accept a block this cycle |
| inData | input | 128 | Input block |
| cipReq | output | 1 | Request pulse to the cipher core |
| cipDecrypt | output | 1 | Direction for the cipher core |
| cipIn | output | 128 | Cipher core input word |
| cipAck | input | 1 | Cipher core result valid |
| cipOut | input | 128 | Cipher core result |
| outValid | output | 1 | Output block valid pulse |
| outData | output | 128 | Output block |

## Verification
The hardest condition to reach from the ports is the counter field rolling over from all ones to zero. Reaching it by stepping the counter is not practical. The stimulus loads a vector whose low field is two short of the wrap, then runs three counter blocks, so the rollover happens on the third block with a nonce that must survive unchanged. A second hard case is a vector write that lands while a block is waiting on the cipher. The stimulus pulses the write port in the request cycle of a CBC block. It then shows through the following block's output that the chain and the stored vector kept their values.

// File: rtl/chain_pkg.sv
package chain_pkg;

  localparam logic [1:0] MODE_ECB = 2'd0;
  localparam logic [1:0] MODE_CBC = 2'd1;
  localparam logic [1:0] MODE_CTR = 2'd2;

  typedef struct packed {
    logic       capture;
    logic       loadIv;
    logic       reloadChain;
    logic       updateChain;
    logic       busy;
    logic [1:0] mode;
    logic       dec;
  } chainCtl_t;

  function automatic logic [1:0] normMode(input logic [1:0] m);
    return (m == MODE_CBC || m == MODE_CTR) ? m : MODE_ECB;
  endfunction

endpackage

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       decrypt,
  input  logic       ivWrite,
  input  logic       inValid,
  output logic       inReady,
  output logic       cipReq,
  output logic       cipDecrypt,
  input  logic       cipAck,
  output logic       outValid,
  output chainCtl_t  ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_t;

  state_t     state;
  logic [1:0] modeReg;
  logic [1:0] lastMode;
  logic       decReg;
  logic       idle;
  logic       accept;

  always_comb begin
    idle            = (state == ST_IDLE);
    inReady         = idle && !ivWrite;
    accept          = inValid && inReady;
    cipReq          = (state == ST_REQ);
    cipDecrypt      = decReg && (modeReg != MODE_CTR);
    ctl.capture     = accept;
    ctl.loadIv      = idle && ivWrite;
    ctl.reloadChain = idle && !ivWrite && (normMode(mode) != lastMode);
    ctl.updateChain = (state == ST_WAIT) && cipAck;
    ctl.busy        = !idle;
    ctl.mode        = modeReg;
    ctl.dec         = decReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeReg  <= MODE_ECB;
      lastMode <= MODE_ECB;
      decReg   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.updateChain;
      if (idle) lastMode <= normMode(mode);
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_REQ;
          modeReg <= normMode(mode);
          decReg  <= decrypt;
        end
        ST_REQ:  state <= ST_WAIT;
        ST_WAIT: if (cipAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_follows_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> cipReq);
  assert_req_single_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    cipReq |=> !cipReq);
  assert_out_after_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && cipAck) |=> outValid);
  assert_out_single_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import chain_pkg::*;
#(
  parameter int BLOCK_W = 128,
  parameter int CTR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  chainCtl_t          ctl,
  input  logic [BLOCK_W-1:0] inData,
  input  logic [BLOCK_W-1:0] ivIn,
  input  logic [BLOCK_W-1:0] cipOut,
  output logic [BLOCK_W-1:0] cipIn,
  output logic [BLOCK_W-1:0] outData
);

  localparam int NONCE_W = BLOCK_W - CTR_W;

  logic [BLOCK_W-1:0] dataReg, chainReg, ivReg, outReg;
  logic [BLOCK_W-1:0] result, nextChain;
  logic [CTR_W-1:0]   ctrNext;

  always_comb begin
    ctrNext = chainReg[CTR_W-1:0] + CTR_W'(1);
    unique case (ctl.mode)
      MODE_CBC: begin
        cipIn     = ctl.dec ? dataReg : (dataReg ^ chainReg);
        result    = ctl.dec ? (cipOut ^ chainReg) : cipOut;
        nextChain = ctl.dec ? dataReg : cipOut;
      end
      MODE_CTR: begin
        cipIn     = chainReg;
        result    = cipOut ^ dataReg;
        nextChain = {chainReg[BLOCK_W-1:CTR_W], ctrNext};
      end
      default: begin
        cipIn     = dataReg;
        result    = cipOut;
        nextChain = chainReg;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      chainReg <= '0;
      ivReg    <= '0;
      outReg   <= '0;
    end else begin
      if (ctl.capture) dataReg <= inData;
      if (ctl.loadIv) begin
        ivReg    <= ivIn;
        chainReg <= ivIn;
      end else if (ctl.reloadChain) begin
        chainReg <= ivReg;
      end else if (ctl.updateChain) begin
        chainReg <= nextChain;
      end
      if (ctl.updateChain) outReg <= result;
    end
  end

  assign outData = outReg;

  assert_iv_held_when_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !ctl.updateChain) |=> (ivReg == $past(ivReg) && chainReg == $past(chainReg)));
  assert_ctr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updateChain && ctl.mode == MODE_CTR) |=>
      (chainReg[BLOCK_W-1:CTR_W] == $past(chainReg[BLOCK_W-1:CTR_W]) &&
       chainReg[CTR_W-1:0] == $past(chainReg[CTR_W-1:0]) + CTR_W'(1)));
  assert_cbc_chain_is_output_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updateChain && ctl.mode == MODE_CBC && !ctl.dec) |=> (chainReg == outReg));
  assert_reload_from_iv_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.reloadChain |=> (chainReg == ivReg));

  if (NONCE_W < 1) begin : g_badWidth
    initial $error("counter field must be narrower than the block");
  end

endmodule

// File: rtl/block_chain_unit.sv
module block_chain_unit
  import chain_pkg::*;
#(
  parameter int BLOCK_W = 128,
  parameter int CTR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               decrypt,
  input  logic               ivWrite,
  input  logic [BLOCK_W-1:0] ivIn,
  input  logic               inValid,
  output logic               inReady,
  input  logic [BLOCK_W-1:0] inData,
  output logic               cipReq,
  output logic               cipDecrypt,
  output logic [BLOCK_W-1:0] cipIn,
  input  logic               cipAck,
  input  logic [BLOCK_W-1:0] cipOut,
  output logic               outValid,
  output logic [BLOCK_W-1:0] outData
);

  chainCtl_t ctl;

  chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .decrypt(decrypt), .ivWrite(ivWrite),
    .inValid(inValid), .inReady(inReady), .cipReq(cipReq), .cipDecrypt(cipDecrypt),
    .cipAck(cipAck), .outValid(outValid), .ctl(ctl)
  );

  chain_datapath #(.BLOCK_W(BLOCK_W), .CTR_W(CTR_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .ivIn(ivIn),
    .cipOut(cipOut), .cipIn(cipIn), .outData(outData)
  );

endmodule

// File: tb/block_chain_unit_test.sv
`timescale 1ns/1ps
module block_chain_unit_test;

  localparam logic [127:0] KEY = 128'h3c5a_9e01_77d2_4b18_c0fe_1234_a5a5_0f0f;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         decrypt = 1'b0;
  logic         ivWrite = 1'b0;
  logic [127:0] ivIn = '0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inData = '0;
  logic         cipReq, cipDecrypt;
  logic [127:0] cipIn;
  logic         cipAck = 1'b0;
  logic [127:0] cipOut = '0;
  logic         outValid;
  logic [127:0] outData;

  int checks = 0;
  int fails = 0;
  logic lastDir = 1'b0;

  always #4 clk = ~clk;

  block_chain_unit uut (
    .clk(clk), .rstN(rstN), .mode(mode), .decrypt(decrypt), .ivWrite(ivWrite),
    .ivIn(ivIn), .inValid(inValid), .inReady(inReady), .inData(inData),
    .cipReq(cipReq), .cipDecrypt(cipDecrypt), .cipIn(cipIn), .cipAck(cipAck),
    .cipOut(cipOut), .outValid(outValid), .outData(outData)
  );

  function automatic logic [127:0] encF(input logic [127:0] x);
    return {x[114:0], x[127:115]} ^ KEY;
  endfunction

  function automatic logic [127:0] decF(input logic [127:0] y);
    logic [127:0] t;
    t = y ^ KEY;
    return {t[12:0], t[127:13]};
  endfunction

  // stand-in cipher core: answers two cycles after each request
  initial begin
    logic [127:0] reqIn;
    logic         reqDec;
    forever begin
      @(negedge clk);
      if (cipReq) begin
        reqIn  = cipIn;
        reqDec = cipDecrypt;
        lastDir = cipDecrypt;
        @(negedge clk);
        @(negedge clk);
        cipOut = reqDec ? decF(reqIn) : encF(reqIn);
        cipAck = 1'b1;
        @(negedge clk);
        cipAck = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setIv(input logic [127:0] v);
    @(negedge clk);
    ivWrite = 1'b1;
    ivIn = v;
    @(negedge clk);
    ivWrite = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m, input logic d);
    @(negedge clk);
    mode = m;
    decrypt = d;
  endtask

  task automatic xfer(input logic [127:0] d, output logic [127:0] r);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inData = d;
    @(negedge clk);
    inValid = 1'b0;
    while (!outValid) @(negedge clk);
    r = outData;
  endtask

  task automatic testReset();
    logic [127:0] r;
    check("R1 inReady after reset", 128'(inReady), 128'd1);
    check("R1 outValid after reset", 128'(outValid), 128'd0);
    check("R1 cipReq after reset", 128'(cipReq), 128'd0);
    setMode(2'd1, 1'b0);
    xfer(128'h1111, r);
    check("R1 CBC chains against zero vector", r, encF(128'h1111));
  endtask

  task automatic testEcb();
    logic [127:0] p, r1, r2;
    p = 128'hdead_beef_0123_4567_89ab_cdef_0f1e_2d3c;
    setIv(128'h5555);
    setMode(2'd0, 1'b0);
    xfer(p, r1);
    check("R2 ECB encrypt", r1, encF(p));
    check("R3 ECB encrypt direction", 128'(lastDir), 128'd0);
    xfer(p, r2);
    check("R2 ECB blocks independent", r2, r1);
    setMode(2'd3, 1'b0);
    xfer(p, r2);
    check("R2 mode 3 acts as ECB", r2, encF(p));
    setMode(2'd0, 1'b1);
    xfer(r1, r2);
    check("R2 ECB decrypt", r2, p);
    check("R3 ECB decrypt direction", 128'(lastDir), 128'd1);
  endtask

  task automatic testCbcEnc();
    logic [127:0] iv, p1, p2, c1, c2, r;
    iv = 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10;
    p1 = 128'haaaa_0000_bbbb_1111_cccc_2222_dddd_3333;
    p2 = 128'h1234_5678_9abc_def0_fedc_ba98_7654_3210;
    c1 = encF(p1 ^ iv);
    c2 = encF(p2 ^ c1);
    setMode(2'd1, 1'b0);
    setIv(iv);
    xfer(p1, r);
    check("R5 CBC first block uses vector", r, c1);
    xfer(p2, r);
    check("R4 CBC second block chains ciphertext", r, c2);
    setIv(iv);
    xfer(p1, r);
    check("R9 vector write restarts CBC chain", r, c1);
  endtask

  task automatic testCbcDec();
    logic [127:0] iv, p1, p2, c1, c2, r;
    iv = 128'hffee_ddcc_bbaa_9988_7766_5544_3322_1100;
    p1 = 128'h0bad_cafe_0000_0001_0000_0002_0000_0003;
    p2 = 128'h7777_8888_9999_aaaa_bbbb_cccc_dddd_eeee;
    c1 = encF(p1 ^ iv);
    c2 = encF(p2 ^ c1);
    setMode(2'd1, 1'b1);
    setIv(iv);
    xfer(c1, r);
    check("R6 CBC decrypt first block", r, p1);
    check("R3 CBC decrypt direction", 128'(lastDir), 128'd1);
    xfer(c2, r);
    check("R6 CBC decrypt second block", r, p2);
  endtask

  task automatic testCtr();
    logic [127:0] iv, r;
    logic [95:0]  nonce;
    logic [127:0] p [3];
    logic [127:0] c [3];
    nonce = 96'h0a0b_0c0d_0e0f_1011_1213_1415;
    iv = {nonce, 32'hffff_fffe};
    p[0] = 128'h1;
    p[1] = 128'hcafe_f00d_0000_0000_1111_2222_3333_4444;
    p[2] = 128'h9999_0000_9999_0000_9999_0000_9999_0000;
    setMode(2'd2, 1'b0);
    setIv(iv);
    xfer(p[0], c[0]);
    check("R7 CTR block at counter fffffffe", c[0], encF(iv) ^ p[0]);
    xfer(p[1], c[1]);
    check("R7 CTR counter advances", c[1], encF({nonce, 32'hffff_ffff}) ^ p[1]);
    xfer(p[2], c[2]);
    check("R7 CTR counter wraps, nonce kept", c[2], encF({nonce, 32'h0}) ^ p[2]);
    check("R8 CTR encrypt uses encrypt direction", 128'(lastDir), 128'd0);
    setMode(2'd2, 1'b1);
    setIv(iv);
    for (int i = 0; i < 3; i++) begin
      xfer(c[i], r);
      check("R7 CTR decrypt recovers data", r, p[i]);
    end
    check("R8 CTR decrypt uses encrypt direction", 128'(lastDir), 128'd0);
  endtask

  task automatic testModeSwitch();
    logic [127:0] iv, p, r;
    iv = 128'h4242_4242_0000_ffff_1234_0000_5678_abcd;
    p = 128'h0f0f_f0f0_1234_4321_abcd_dcba_5a5a_a5a5;
    setMode(2'd1, 1'b0);
    setIv(iv);
    xfer(p, r);
    check("R5 CBC block before mode switch", r, encF(p ^ iv));
    setMode(2'd0, 1'b0);
    xfer(p, r);
    check("R2 ECB block between CBC runs", r, encF(p));
    setMode(2'd1, 1'b0);
    xfer(p, r);
    check("R9 mode change reloads stored vector", r, encF(p ^ iv));
  endtask

  task automatic testBusyIvWrite();
    logic [127:0] iv, p1, p2, c1, r;
    iv = 128'h1357_9bdf_2468_ace0_1122_3344_5566_7788;
    p1 = 128'h0000_1111_2222_3333_4444_5555_6666_7777;
    p2 = 128'h8888_9999_aaaa_bbbb_cccc_dddd_eeee_ffff;
    c1 = encF(p1 ^ iv);
    setMode(2'd1, 1'b0);
    setIv(iv);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inData = p1;
    @(negedge clk);
    inValid = 1'b0;
    check("R11 cipReq in cycle after accept", 128'(cipReq), 128'd1);
    check("R11 inReady low while busy", 128'(inReady), 128'd0);
    ivWrite = 1'b1;
    ivIn = 128'hbad0_bad0_bad0_bad0_bad0_bad0_bad0_bad0;
    @(negedge clk);
    ivWrite = 1'b0;
    check("R11 cipReq is one cycle", 128'(cipReq), 128'd0);
    wait (cipAck);
    @(negedge clk);
    check("R11 outValid in cycle after ack", 128'(outValid), 128'd1);
    check("R10 block result unaffected by busy write", outData, c1);
    @(negedge clk);
    check("R11 outValid is one cycle", 128'(outValid), 128'd0);
    xfer(p2, r);
    check("R10 chain kept after busy write", r, encF(p2 ^ c1));
    setMode(2'd0, 1'b0);
    setMode(2'd1, 1'b0);
    xfer(p1, r);
    check("R10 stored vector kept after busy write", r, c1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEcb();
    testCbcEnc();
    testCbcDec();
    testCtr();
    testModeSwitch();
    testBusyIvWrite();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule